// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests from an external active-low maskable pin, an active-low non-maskable pin and a parameterized set of internal peripheral request lines. It picks one winner and presents it to a CPU core as a request strobe. The winner comes with a source number and the address of that source's vector entry. The CPU answers with an accept pulse when it takes the interrupt and a return pulse when the handler ends. The block holds the two status mask bits that gate the request classes. It keeps a small stack of saved group-mask values so that handlers can nest.

A 4-bit select field lifts any one maskable source above the fixed index order. The external pin is either level sensitive or falling-edge sensitive. That choice is accepted only during a short configuration window that starts when reset is released. The non-maskable pin is always edge detected, so a pin that stays low raises one request and no more.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The group mask `gmask` is 1 after reset. While it is 1, no maskable source raises `irq_req`. A `sw_clr_gmask` pulse clears it and a `sw_set_gmask` pulse sets it.
- R2: The non-maskable mask `nmask` is 1 after reset and a `sw_clr_nmask` pulse clears it. No input can set it again before the next reset. Falling edges on `nmi_n` while `nmask` is 1 are discarded.
- R3: An `ack` pulse while `irq_req` is 1 sets `gmask`. An `rti` pulse restores `gmask` to the value it held at the matching accept, most recent first.
- R4: In the default level mode, the external source is pending exactly while `ext_irq_n` is sampled low. Nothing is latched.
- R5: Edge mode is selected by a `cfg_edge_wr` pulse with `cfg_edge_val`=1 (0 selects level mode). The write takes effect only within the first 64 clock cycles after reset is released. Later writes are ignored.
- R6: In edge mode, a falling edge of `ext_irq_n` is latched until it is accepted. A pin held low after that raises no further request.
- R7: `psel_val` is written by `psel_wr` and resets to 0. The value k promotes maskable source k to top priority, where 0 is the external pin and k≥1 is `periph_req[k-1]`. A value above the last maskable source promotes nothing.
- R8: Apart from the promoted source, the pending maskable source with the lowest index wins. The index is 0 for the external pin and 1+j for `periph_req[j]`.
- R9: With `nmask` clear, a falling edge of `nmi_n` raises a request that beats every maskable source and ignores `gmask`. An accept clears it, and it fires once per edge.
- R10: `irq_src` is 0 for the non-maskable source, 1 for the external pin and 2+j for `periph_req[j]`. `irq_vec` = 0xFFFC − 2·`irq_src`, which stays within 0xFFC0..0xFFFF.
- R11: If a handler clears `gmask`, a new maskable request is raised again and can be accepted on top of the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_n | input | 1 | External maskable request, active low |
| nmi_n | input | 1 | Non-maskable request, active low, edge detected |
| periph_req | input | N_PERIPH | Internal peripheral request levels, active high |
| sw_set_gmask | input | 1 | Pulse: set group mask |
| sw_clr_gmask | input | 1 | Pulse: clear group mask |
| sw_clr_nmask | input | 1 | Pulse: clear non-maskable mask (one way) |
| cfg_edge_wr | input | 1 | Pulse: write external pin mode |
| cfg_edge_val | input | 1 | 1 = falling edge, 0 = level |
| psel_wr | input | 1 | Pulse: write priority-select field |
| psel_val | input | PSEL_W | Maskable source to promote |
| ack | input | 1 | CPU accepts the presented request |
| rti | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | Request strobe to the CPU |
| irq_src | output | 5 | Winning source number |
| irq_vec | output | 16 | Vector entry address of the winner |
| gmask | output | 1 | Group mask status bit |
| nmask | output | 1 | Non-maskable mask status bit |

## Verification
Winner selection is driven with random peripheral patterns and random external pin levels under every select value. That includes select values past the last source, which must leave the plain index order in force. Each outcome is compared against a bench model, so a wrong promotion is told apart from a wrong fallback order. Directed sequences cover the remaining behaviour. A pin is held low after an accept, which separates latched edge requests from level ones. Nested accepts and returns show that mask values come back in last-in-first-out order. A late mode write shows that the configuration window has closed. A non-maskable edge arrives while the mask is still set and must be dropped.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
   localparam int          SRC_W     = 5;
   localparam int          MAX_ID    = 30;
   localparam logic [15:0] VEC_TOP   = 16'hFFFC;

   function automatic logic [15:0] vec_of(input logic [SRC_W-1:0] id);
      return VEC_TOP - {10'd0, id, 1'b0};
   endfunction
endpackage

// File: rtl/irq_src_cond.sv
`timescale 1ns/1ps
module irq_src_cond #(
   parameter int N_PERIPH   = 6,
   parameter int CFG_WINDOW = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_irq_n,
   input  logic                nmi_n,
   input  logic [N_PERIPH-1:0] periph_req,
   input  logic                cfg_edge_wr,
   input  logic                cfg_edge_val,
   input  logic                nmask,
   input  logic                clr_ext,
   input  logic                clr_nmi,
   output logic [N_PERIPH:0]   pend_m,
   output logic                nmi_pend
);
   localparam int CNT_W = $clog2(CFG_WINDOW + 2);

   generate
      if (CFG_WINDOW < 1) begin : g_bad_window
         $error("CFG_WINDOW must be at least 1");
      end
   endgenerate

   logic                ext_q, ext_d, nmi_q, nmi_d;
   logic                edge_mode, ext_lat, win_open, ext_now;
   logic [N_PERIPH-1:0] per_q;
   logic [CNT_W-1:0]    age;

   assign win_open = (age < CNT_W'(CFG_WINDOW));
   assign ext_now  = edge_mode ? ext_lat : ~ext_q;
   assign pend_m   = {per_q, ext_now};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_q     <= 1'b1;
         ext_d     <= 1'b1;
         nmi_q     <= 1'b1;
         nmi_d     <= 1'b1;
         per_q     <= '0;
         age       <= '0;
         edge_mode <= 1'b0;
         ext_lat   <= 1'b0;
         nmi_pend  <= 1'b0;
      end else begin
         ext_q <= ext_irq_n;
         ext_d <= ext_q;
         nmi_q <= nmi_n;
         nmi_d <= nmi_q;
         per_q <= periph_req;
         if (win_open) begin
            age <= age + CNT_W'(1);
            if (cfg_edge_wr) edge_mode <= cfg_edge_val;
         end
         ext_lat  <= edge_mode & ((ext_lat & ~clr_ext) | (ext_d & ~ext_q));
         nmi_pend <= (nmi_pend & ~clr_nmi) | (~nmask & nmi_d & ~nmi_q);
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
   parameter int NUM_M  = 7,
   parameter int PSEL_W = 4
) (
   input  logic [NUM_M-1:0]         pend,
   input  logic [PSEL_W-1:0]        psel,
   output logic                     any,
   output logic [irq_pkg::SRC_W-1:0] win
);
   localparam int SRC_W = irq_pkg::SRC_W;

   logic [NUM_M-1:0] hit;

   generate
      for (genvar k = 0; k < NUM_M; k++) begin : g_promo
         assign hit[k] = pend[k] && (psel == PSEL_W'(k));
      end
   endgenerate

   always_comb begin
      any = |pend;
      win = '0;
      for (int i = NUM_M - 1; i >= 0; i--) begin
         if (pend[i]) win = SRC_W'(i);
      end
      if (|hit) win = SRC_W'(psel);
   end
endmodule

// File: rtl/irq_mask_ctl.sv
`timescale 1ns/1ps
module irq_mask_ctl #(
   parameter int NEST_DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic rti,
   input  logic sw_set_g,
   input  logic sw_clr_g,
   input  logic sw_clr_n,
   output logic gmask,
   output logic nmask
);
   generate
      if (NEST_DEPTH < 1) begin : g_bad_depth
         $error("NEST_DEPTH must be at least 1");
      end
   endgenerate

   logic [NEST_DEPTH-1:0] saved, push_v, pop_v;

   generate
      if (NEST_DEPTH == 1) begin : g_single
         assign push_v = gmask;
         assign pop_v  = 1'b1;
      end else begin : g_stack
         assign push_v = {saved[NEST_DEPTH-2:0], gmask};
         assign pop_v  = {1'b1, saved[NEST_DEPTH-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gmask <= 1'b1;
         nmask <= 1'b1;
         saved <= '1;
      end else begin
         if (take) begin
            gmask <= 1'b1;
            saved <= push_v;
         end else if (rti) begin
            gmask <= saved[0];
            saved <= pop_v;
         end else if (sw_set_g) begin
            gmask <= 1'b1;
         end else if (sw_clr_g) begin
            gmask <= 1'b0;
         end
         if (sw_clr_n) nmask <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
   parameter int N_PERIPH   = 6,
   parameter int PSEL_W     = 4,
   parameter int CFG_WINDOW = 64,
   parameter int NEST_DEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ext_irq_n,
   input  logic                      nmi_n,
   input  logic [N_PERIPH-1:0]       periph_req,
   input  logic                      sw_set_gmask,
   input  logic                      sw_clr_gmask,
   input  logic                      sw_clr_nmask,
   input  logic                      cfg_edge_wr,
   input  logic                      cfg_edge_val,
   input  logic                      psel_wr,
   input  logic [PSEL_W-1:0]         psel_val,
   input  logic                      ack,
   input  logic                      rti,
   output logic                      irq_req,
   output logic [irq_pkg::SRC_W-1:0] irq_src,
   output logic [15:0]               irq_vec,
   output logic                      gmask,
   output logic                      nmask
);
   localparam int SRC_W = irq_pkg::SRC_W;
   localparam int NUM_M = N_PERIPH + 1;

   generate
      if (N_PERIPH < 1 || N_PERIPH > irq_pkg::MAX_ID - 1) begin : g_bad_count
         $error("N_PERIPH out of range for the vector table");
      end
      if (NUM_M > (1 << PSEL_W)) begin : g_bad_psel
         $error("PSEL_W too narrow to name every maskable source");
      end
   endgenerate

   logic [NUM_M-1:0]  pend_m;
   logic              nmi_pend, any_m, take, clr_ext, clr_nmi;
   logic [SRC_W-1:0]  m_win;
   logic [PSEL_W-1:0] psel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       psel_q <= '0;
      else if (psel_wr) psel_q <= psel_val;
   end

   irq_src_cond #(.N_PERIPH(N_PERIPH), .CFG_WINDOW(CFG_WINDOW)) u_cond (
      .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .nmi_n(nmi_n),
      .periph_req(periph_req), .cfg_edge_wr(cfg_edge_wr),
      .cfg_edge_val(cfg_edge_val), .nmask(nmask), .clr_ext(clr_ext),
      .clr_nmi(clr_nmi), .pend_m(pend_m), .nmi_pend(nmi_pend)
   );

   irq_arbiter #(.NUM_M(NUM_M), .PSEL_W(PSEL_W)) u_arb (
      .pend(pend_m), .psel(psel_q), .any(any_m), .win(m_win)
   );

   irq_mask_ctl #(.NEST_DEPTH(NEST_DEPTH)) u_mask (
      .clk(clk), .rst_n(rst_n), .take(take), .rti(rti),
      .sw_set_g(sw_set_gmask), .sw_clr_g(sw_clr_gmask),
      .sw_clr_n(sw_clr_nmask), .gmask(gmask), .nmask(nmask)
   );

   assign irq_req = nmi_pend | (any_m & ~gmask);
   assign irq_src = nmi_pend ? '0 : m_win + SRC_W'(1);
   assign irq_vec = irq_pkg::vec_of(irq_src);
   assign take    = ack & irq_req;
   assign clr_nmi = take & nmi_pend;
   assign clr_ext = take & ~nmi_pend & (m_win == '0);
endmodule

// File: rtl/irq_prio_chk.sv
`timescale 1ns/1ps
module irq_prio_chk (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ack,
   input logic                      rti,
   input logic                      sw_set_gmask,
   input logic                      sw_clr_gmask,
   input logic                      irq_req,
   input logic [irq_pkg::SRC_W-1:0] irq_src,
   input logic [15:0]               irq_vec,
   input logic                      gmask,
   input logic                      nmask
);
   AST_ACK_SETS_GMASK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_req) |=> gmask); // R3
   AST_GMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && gmask) |-> (irq_src == '0)); // R1
   AST_CLR_GMASK: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_gmask && !sw_set_gmask && !(ack && irq_req) && !rti) |=> !gmask); // R1
   AST_NMASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !nmask |=> !nmask); // R2
   AST_NMI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      nmask |-> !(irq_req && irq_src == '0)); // R2
   AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec >= 16'hFFC0 && !irq_vec[0])); // R10
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .rti(rti),
   .sw_set_gmask(sw_set_gmask), .sw_clr_gmask(sw_clr_gmask),
   .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec),
   .gmask(gmask), .nmask(nmask)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
   localparam int NP = 6;

   logic          clk = 1'b0;
   logic          rst_n, ext_irq_n, nmi_n;
   logic [NP-1:0] periph_req;
   logic          sw_set_gmask, sw_clr_gmask, sw_clr_nmask;
   logic          cfg_edge_wr, cfg_edge_val, psel_wr, ack, rti;
   logic [3:0]    psel_val;
   logic          irq_req, gmask, nmask;
   logic [4:0]    irq_src;
   logic [15:0]   irq_vec;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_prio_ctrl i_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .nmi_n(nmi_n),
      .periph_req(periph_req), .sw_set_gmask(sw_set_gmask),
      .sw_clr_gmask(sw_clr_gmask), .sw_clr_nmask(sw_clr_nmask),
      .cfg_edge_wr(cfg_edge_wr), .cfg_edge_val(cfg_edge_val),
      .psel_wr(psel_wr), .psel_val(psel_val), .ack(ack), .rti(rti),
      .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec),
      .gmask(gmask), .nmask(nmask)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // 0 ack, 1 rti, 2 set gmask, 3 clr gmask, 4 clr nmask
   task automatic pulse(input int which);
      case (which)
         0: ack = 1'b1;
         1: rti = 1'b1;
         2: sw_set_gmask = 1'b1;
         3: sw_clr_gmask = 1'b1;
         default: sw_clr_nmask = 1'b1;
      endcase
      tick(1);
      ack = 0; rti = 0; sw_set_gmask = 0; sw_clr_gmask = 0; sw_clr_nmask = 0;
   endtask

   task automatic write_psel(input logic [3:0] v);
      psel_val = v; psel_wr = 1'b1; tick(1); psel_wr = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick(3); rst_n = 1'b1;
   endtask

   // expected outcome: -1 when nothing is requested, else packed {vec, src}
   function automatic int model(input logic en, input logic [NP-1:0] per, input int ps);
      logic [NP:0] p;
      int id;
      p = {per, ~en};
      if (p == '0) return -1;
      id = -1;
      for (int i = NP; i >= 0; i--) if (p[i]) id = i + 1;
      if (ps <= NP && p[ps]) id = ps + 1;
      return {(16'hFFFC - 16'(2 * id)), 5'(id)};
   endfunction

   function automatic int observed();
      return irq_req ? int'({irq_vec, irq_src}) : -1;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 0; ext_irq_n = 1; nmi_n = 1; periph_req = '0;
      sw_set_gmask = 0; sw_clr_gmask = 0; sw_clr_nmask = 0;
      cfg_edge_wr = 0; cfg_edge_val = 0; psel_wr = 0; psel_val = '0;
      ack = 0; rti = 0;
      do_reset();
      tick(1);
      expect_eq("R1 reset gmask", gmask, 1);
      expect_eq("R2 reset nmask", nmask, 1);
      expect_eq("R1 reset req", irq_req, 0);

      ext_irq_n = 0; periph_req = '1; tick(3);
      expect_eq("R1 masked sources blocked", irq_req, 0);
      pulse(3); tick(1);
      expect_eq("R1 gmask cleared", gmask, 0);
      expect_eq("R7 default promotes ext", irq_src, 1);
      expect_eq("R10 ext vector", irq_vec, 16'hFFFA);

      // directed priority cases
      ext_irq_n = 1; periph_req = 6'b000101; write_psel(4'd3); tick(2);
      expect_eq("R7 promote periph idx 3", observed(), model(1'b1, 6'b000101, 3));
      write_psel(4'd9); tick(2);
      expect_eq("R7 out-of-range select", observed(), model(1'b1, 6'b000101, 9));
      periph_req = 6'b101000; write_psel(4'd15); tick(2);
      expect_eq("R8 lowest index wins", irq_src, 5);

      for (int it = 0; it < 300; it++) begin
         logic [NP-1:0] pr;
         logic en;
         logic [3:0] ps;
         pr = NP'($urandom & $urandom);
         en = 1'($urandom);
         ps = 4'($urandom);
         periph_req = pr; ext_irq_n = en; write_psel(ps); tick(2);
         expect_eq("R8 random arbitration", observed(), model(en, pr, int'(ps)));
      end

      periph_req = '0; ext_irq_n = 1; write_psel(4'd0); tick(2);
      ext_irq_n = 0; tick(2);
      expect_eq("R4 level pending", irq_req, 1);
      ext_irq_n = 1; tick(2);
      expect_eq("R4 level not latched", irq_req, 0);

      ext_irq_n = 0; tick(2);
      pulse(0); tick(1);
      expect_eq("R3 accept sets gmask", gmask, 1);
      expect_eq("R3 masked after accept", irq_req, 0);
      pulse(1); tick(1);
      expect_eq("R3 return restores", gmask, 0);
      pulse(0); pulse(3); tick(1);
      expect_eq("R11 nested request raised", irq_req, 1);
      pulse(0); tick(1);
      expect_eq("R11 nested accept masks", gmask, 1);
      pulse(1); tick(1);
      expect_eq("R3 inner return", gmask, 0);
      pulse(2); pulse(1); tick(1);
      expect_eq("R3 outer return restores 0", gmask, 0);
      ext_irq_n = 1;

      pulse(2);
      nmi_n = 0; tick(2); nmi_n = 1; tick(3);
      expect_eq("R2 nmi ignored while masked", irq_req, 0);
      pulse(4); tick(1);
      expect_eq("R2 nmask cleared", nmask, 0);
      nmi_n = 0; tick(3);
      expect_eq("R9 nmi despite gmask", observed(), {16'hFFFC, 5'd0});
      pulse(3); periph_req = '1; ext_irq_n = 0; tick(3);
      expect_eq("R9 nmi beats maskable", irq_src, 0);
      pulse(0); tick(3);
      expect_eq("R9 held low fires once", irq_req, 0);
      pulse(1); tick(1);
      expect_eq("R9 maskable after nmi", irq_src, 1);
      expect_eq("R2 nmask stays clear", nmask, 0);
      nmi_n = 1; periph_req = '0; ext_irq_n = 1; tick(2);

      // edge mode phase
      do_reset(); tick(1);
      expect_eq("R2 nmask set again by reset", nmask, 1);
      cfg_edge_val = 1; cfg_edge_wr = 1; tick(1); cfg_edge_wr = 0;
      pulse(3);
      ext_irq_n = 0; tick(1); ext_irq_n = 1; tick(3);
      expect_eq("R6 short edge latched", irq_src, 1);
      expect_eq("R5 edge mode accepted", irq_req, 1);
      pulse(0); pulse(1); tick(2);
      expect_eq("R6 latch cleared by accept", irq_req, 0);
      ext_irq_n = 0; tick(3);
      expect_eq("R6 new edge", irq_req, 1);
      pulse(0); pulse(1); tick(3);
      expect_eq("R6 held low fires once", irq_req, 0);
      ext_irq_n = 1; tick(80);
      cfg_edge_val = 0; cfg_edge_wr = 1; tick(1); cfg_edge_wr = 0;
      ext_irq_n = 0; tick(3);
      pulse(0); pulse(1); tick(3);
      expect_eq("R5 late level write ignored", irq_req, 0);
      ext_irq_n = 1; tick(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule